// File: doc/BRIEF.md
# UART Receive/Transmit Line Status Unit

This block produces the 8-bit line status word of one UART channel. Characters arrive from an external deserializer together with their parity and framing verdicts. The block queues each character in a receive queue with its error tags. In queue mode the queue holds up to `DEPTH` entries; in single-buffer (16450-compatible) mode it holds one entry. The block also watches the serial input on the 16x oversampling tick. When the line stays low for longer than one full frame, it queues a single all-zero character tagged as a break. It then refuses further characters until the line has returned high and a fresh start bit is reported.

On the transmit side, the block tracks a holding-empty flag and combines it with the shift register's empty input to form a transmitter-idle flag. It raises a transmit interrupt request and a receive line interrupt request, each gated by its own enable. The status word is read by the CPU through a read strobe. A read hides the error tags of the character currently at the head until the head changes, and it clears the overrun flag.

Top module: `line_stat_unit`

## Requirements
- R1: After reset the status word reads 0x60 when `txShiftEmpty` is 1: bits 0-4 and 7 are 0, bit 5 (holding empty) and bit 6 (transmitter idle) are 1, and neither interrupt request is asserted while its enable is 0.
- R2: Bit 7 is 1 in queue mode while any occupied receive entry carries a parity, framing or break tag, and 0 otherwise. It is always 0 in single-buffer mode.
- R3: Bit 6 equals bit 5 AND `txShiftEmpty`.
- R4: In single-buffer mode, bit 5 becomes 1 in the cycle after `thrToShift` and 0 in the cycle after `thrWrite`. When both occur in the same cycle the write wins.
- R5: In queue mode, bit 5 follows `txFifoEmpty` one cycle late, and is 0 in the cycle after any `thrWrite`.
- R6: `txIrq` is 1 exactly when `ienThre` is 1 and bit 5 is 1.
- R7: A break is declared on the sampled low tick after the line has already been low for F consecutive ticks, where F = 16*(7 + wordLen + parityEn + twoStop). Here wordLen 0..3 selects 5..8 data bits. The break queues one character with data 0x00 and the break tag set.
- R8: After a break no further break is queued and `rxCharValid` is ignored until a high sample is seen and then `rxStartSeen` is pulsed. An `rxStartSeen` before the high sample has no effect.
- R9: Bits 2 (parity), 3 (framing) and 4 (break) show the tags of the head entry. A status read hides them until the head changes; `rxHeadData` shows the head character.
- R10: Characters leave the receive queue in arrival order; `rxPop` advances the head and is ignored when the queue is empty.
- R11: Bit 1 (overrun) sets when a character arrives with no room. In queue mode the character is dropped; in single-buffer mode it replaces the held one. Bit 1 clears on a status read.
- R12: `lineIrq` is 1 exactly when `ienLineStat` is 1 and any of bits 1-4 is 1.
- R13: Bit 0 is 1 while the receive queue holds at least one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoMode | input | 1 | 1 = queue mode, 0 = single-buffer mode |
| wordLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Parity bit present in frame |
| twoStop | input | 1 | Two stop bits instead of one |
| sampleTick | input | 1 | 16x oversampling strobe |
| serialIn | input | 1 | Serial receive line |
| rxStartSeen | input | 1 | Deserializer found a valid start bit |
| rxCharValid | input | 1 | Deserializer delivers a character |
| rxCharData | input | 8 | Delivered character |
| rxParityErr | input | 1 | Parity error of delivered character |
| rxFrameErr | input | 1 | Framing error of delivered character |
| rxPop | input | 1 | CPU reads the receive buffer |
| statusRead | input | 1 | CPU reads the status word |
| thrWrite | input | 1 | CPU writes the holding register / Tx queue |
| thrToShift | input | 1 | Holding register moved to shift register |
| txFifoEmpty | input | 1 | Tx queue is empty |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| ienThre | input | 1 | Transmit-empty interrupt enable |
| ienLineStat | input | 1 | Receive line status interrupt enable |
| statusReg | output | 8 | Line status word |
| rxHeadData | output | 8 | Character at the receive head |
| txIrq | output | 1 | Transmit-empty interrupt request |
| lineIrq | output | 1 | Receive line status interrupt request |

## Verification
The queue is filled with a mix of clean, parity-bad, framing-bad and doubly bad characters and then drained. This separates head-only tag reporting from the whole-queue error summary, which must stay set until the last bad entry leaves. Breaks are held exactly one tick short of and exactly at the threshold for two frame formats, which shows off-by-one errors in the frame-length sum. Characters and start bits are offered before and after the line returns high, which shows whether re-arming needs both events in order. Single-buffer runs use the same patterns to tell overwrite from drop and to show that the summary bit stays 0 there.

// File: rtl/line_stat_pkg.sv
package line_stat_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic     push;
    rxEntry_t entry;
    logic     pop;
    logic     statusRead;
  } rxStrobe_t;

  typedef enum logic [1:0] {
    ARMED      = 2'd0,
    WAIT_MARK  = 2'd1,
    WAIT_START = 2'd2
  } armState_t;
endpackage

// File: rtl/line_stat_ctrl.sv
module line_stat_ctrl
  import line_stat_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic [1:0]        wordLen,
  input  logic              parityEn,
  input  logic              twoStop,
  input  logic              sampleTick,
  input  logic              serialIn,
  input  logic              rxStartSeen,
  input  logic              rxCharValid,
  input  logic [CHAR_W-1:0] rxCharData,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic              rxPop,
  input  logic              statusRead,
  input  logic              thrWrite,
  input  logic              thrToShift,
  input  logic              txFifoEmpty,
  output rxStrobe_t         strobe,
  output logic              threFlag
);
  // longest frame: start + 8 data + parity + 2 stop = 12 bit times
  localparam int MAX_TICKS = OVERSAMPLE * 12;
  localparam int BRK_W     = $clog2(MAX_TICKS + 2);

  armState_t        armState;
  logic [BRK_W-1:0] lowCnt;
  logic [BRK_W-1:0] frameTicks;
  logic             breakHit;
  logic             charAccept;

  // 7 = start + 5 minimum data bits + 1 stop
  always_comb begin
    frameTicks = BRK_W'(OVERSAMPLE) *
                 (BRK_W'(7) + BRK_W'(wordLen) + BRK_W'(parityEn) + BRK_W'(twoStop));
    breakHit   = sampleTick && !serialIn && (armState == ARMED) && (lowCnt == frameTicks);
    charAccept = rxCharValid && (armState == ARMED) && !breakHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (armState != ARMED || breakHit || (sampleTick && serialIn)) begin
      lowCnt <= '0;
    end else if (sampleTick) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armState <= ARMED;
    end else begin
      unique case (armState)
        ARMED:      if (breakHit) armState <= WAIT_MARK;
        WAIT_MARK:  if (sampleTick && serialIn) armState <= WAIT_START;
        WAIT_START: if (rxStartSeen) armState <= ARMED;
        default:    armState <= ARMED;
      endcase
    end
  end

  always_comb begin
    strobe.push       = breakHit || charAccept;
    strobe.pop        = rxPop;
    strobe.statusRead = statusRead;
    if (breakHit) begin
      strobe.entry = '{brk: 1'b1, frm: 1'b0, par: 1'b0, data: '0};
    end else begin
      strobe.entry = '{brk: 1'b0, frm: rxFrameErr, par: rxParityErr, data: rxCharData};
    end
  end

  // holding-empty flag; a CPU write always wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      threFlag <= 1'b1;
    end else if (thrWrite) begin
      threFlag <= 1'b0;
    end else if (fifoMode) begin
      threFlag <= txFifoEmpty;
    end else if (thrToShift) begin
      threFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/line_stat_datapath.sv
module line_stat_datapath
  import line_stat_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  rxStrobe_t         strobe,
  output logic              dataReady,
  output logic              overrun,
  output logic              headPar,
  output logic              headFrm,
  output logic              headBrk,
  output logic              fifoErr,
  output logic [CHAR_W-1:0] headData
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count, capacity;
  logic             headSeen;
  logic             doPop, doWrite, overwrite, dropped, isFull, headChange;
  rxEntry_t         head;

  always_comb begin
    capacity   = fifoMode ? CNT_W'(DEPTH) : CNT_W'(1);
    isFull     = (count == capacity);
    doPop      = strobe.pop && (count != '0);
    doWrite    = 1'b0;
    overwrite  = 1'b0;
    dropped    = 1'b0;
    if (strobe.push) begin
      if (!isFull || doPop) doWrite   = 1'b1;
      else if (!fifoMode)   overwrite = 1'b1;
      else                  dropped   = 1'b1;
    end
    headChange = doPop || overwrite || (doWrite && count == '0);
  end

  always_ff @(posedge clk) begin
    if (doWrite)   mem[wrPtr] <= strobe.entry;
    if (overwrite) mem[rdPtr] <= strobe.entry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      headSeen <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (doWrite) wrPtr <= wrPtr + 1'b1;
      if (doPop)   rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(doWrite) - CNT_W'(doPop);
      if (headChange)             headSeen <= 1'b0;
      else if (strobe.statusRead) headSeen <= 1'b1;
      if (overwrite || dropped)   overrun <= 1'b1;
      else if (strobe.statusRead) overrun <= 1'b0;
    end
  end

  always_comb begin
    logic [PTR_W-1:0] offs;
    logic             anyErr;
    anyErr = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      offs = PTR_W'(i) - rdPtr;
      if (CNT_W'(offs) < count) anyErr = anyErr | mem[i].par | mem[i].frm | mem[i].brk;
    end
    fifoErr   = fifoMode && anyErr;
    head      = mem[rdPtr];
    dataReady = (count != '0);
    headPar   = dataReady && !headSeen && head.par;
    headFrm   = dataReady && !headSeen && head.frm;
    headBrk   = dataReady && !headSeen && head.brk;
    headData  = dataReady ? head.data : '0;
  end
endmodule

// File: rtl/line_stat_unit.sv
module line_stat_unit
  import line_stat_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoMode,
  input  logic [1:0]  wordLen,
  input  logic        parityEn,
  input  logic        twoStop,
  input  logic        sampleTick,
  input  logic        serialIn,
  input  logic        rxStartSeen,
  input  logic        rxCharValid,
  input  logic [7:0]  rxCharData,
  input  logic        rxParityErr,
  input  logic        rxFrameErr,
  input  logic        rxPop,
  input  logic        statusRead,
  input  logic        thrWrite,
  input  logic        thrToShift,
  input  logic        txFifoEmpty,
  input  logic        txShiftEmpty,
  input  logic        ienThre,
  input  logic        ienLineStat,
  output logic [7:0]  statusReg,
  output logic [7:0]  rxHeadData,
  output logic        txIrq,
  output logic        lineIrq
);
  rxStrobe_t strobe;
  logic threFlag, dataReady, overrun, headPar, headFrm, headBrk, fifoErr;

  line_stat_ctrl #(.OVERSAMPLE(OVERSAMPLE)) uCtrl (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .wordLen(wordLen),
    .parityEn(parityEn), .twoStop(twoStop), .sampleTick(sampleTick),
    .serialIn(serialIn), .rxStartSeen(rxStartSeen), .rxCharValid(rxCharValid),
    .rxCharData(rxCharData), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .rxPop(rxPop), .statusRead(statusRead), .thrWrite(thrWrite),
    .thrToShift(thrToShift), .txFifoEmpty(txFifoEmpty),
    .strobe(strobe), .threFlag(threFlag)
  );

  line_stat_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .strobe(strobe),
    .dataReady(dataReady), .overrun(overrun), .headPar(headPar),
    .headFrm(headFrm), .headBrk(headBrk), .fifoErr(fifoErr),
    .headData(rxHeadData)
  );

  always_comb begin
    statusReg = {fifoErr, threFlag && txShiftEmpty, threFlag,
                 headBrk, headFrm, headPar, overrun, dataReady};
    txIrq     = ienThre && threFlag;
    lineIrq   = ienLineStat && (overrun || headPar || headFrm || headBrk);
  end
endmodule

// File: rtl/line_stat_checks.sv
module line_stat_checks (
  input logic       clk,
  input logic       rstN,
  input logic       fifoMode,
  input logic       rxPop,
  input logic       statusRead,
  input logic       thrWrite,
  input logic       ienThre,
  input logic       ienLineStat,
  input logic [7:0] statusReg,
  input logic [7:0] rxHeadData,
  input logic       txIrq,
  input logic       lineIrq
);
  AST_SUMMARY_QUIET_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !fifoMode |-> !statusReg[7]);                                       // R2
  AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[6] |-> statusReg[5]);                                     // R3
  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> !statusReg[5]);                                        // R4
  AST_TXIRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !ienThre |-> !txIrq);                                               // R6
  AST_BREAK_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[4] |-> (statusReg[0] && rxHeadData == 8'h00));            // R9
  AST_READ_HIDES_TAGS: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && fifoMode && statusReg[0] && !rxPop) |=> (statusReg[4:2] == 3'b000)); // R9
  AST_LINEIRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !ienLineStat |-> !lineIrq);                                         // R12
endmodule

bind line_stat_unit line_stat_checks uChecks (.*);

// File: tb/sim_line_stat_unit.sv
module sim_line_stat_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoMode = 1'b1;
  logic [1:0] wordLen = 2'd3;
  logic parityEn = 1'b0, twoStop = 1'b0, sampleTick = 1'b1, serialIn = 1'b1;
  logic rxStartSeen = 1'b0, rxCharValid = 1'b0, rxParityErr = 1'b0, rxFrameErr = 1'b0;
  logic [7:0] rxCharData = 8'h00;
  logic rxPop = 1'b0, statusRead = 1'b0, thrWrite = 1'b0, thrToShift = 1'b0;
  logic txFifoEmpty = 1'b1, txShiftEmpty = 1'b1, ienThre = 1'b0, ienLineStat = 1'b0;
  logic [7:0] statusReg, rxHeadData;
  logic txIrq, lineIrq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  line_stat_unit u0 (.*);

  // vector: {parity, framing, data}
  localparam logic [9:0] VEC [6] = '{
    {2'b00, 8'hA5}, {2'b10, 8'h3C}, {2'b01, 8'h0F},
    {2'b11, 8'hFF}, {2'b00, 8'h81}, {2'b00, 8'h42}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic mode);
    rstN = 1'b0;
    fifoMode = mode;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic pushChar(input logic [7:0] d, input logic pe, input logic fe);
    rxCharValid = 1'b1; rxCharData = d; rxParityErr = pe; rxFrameErr = fe;
    cyc(1);
    rxCharValid = 1'b0; rxParityErr = 1'b0; rxFrameErr = 1'b0;
  endtask

  task automatic pulsePop();
    rxPop = 1'b1; cyc(1); rxPop = 1'b0;
  endtask

  task automatic pulseRead();
    statusRead = 1'b1; cyc(1); statusRead = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset(1'b1);
    chk("R1 status", statusReg, 8'h60);
    chk("R1 txIrq", txIrq, 0);
    chk("R12 lineIrq", lineIrq, 0);
    chk("R13 empty", statusReg[0], 0);

    // vector walk: fill then drain
    for (int i = 0; i < 6; i++) pushChar(VEC[i][7:0], VEC[i][9], VEC[i][8]);
    chk("R13 ready", statusReg[0], 1);
    for (int i = 0; i < 6; i++) begin
      logic anyErr;
      anyErr = 1'b0;
      for (int j = i; j < 6; j++) anyErr = anyErr | VEC[j][9] | VEC[j][8];
      chk("R10 head order", rxHeadData, VEC[i][7:0]);
      chk("R9 parity tag", statusReg[2], VEC[i][9]);
      chk("R9 framing tag", statusReg[3], VEC[i][8]);
      chk("R2 summary", statusReg[7], anyErr);
      pulsePop();
    end
    chk("R13 drained", statusReg[0], 0);
    chk("R2 summary drained", statusReg[7], 0);
    pulsePop();
    chk("R10 pop empty ignored", statusReg[0], 0);

    // queue-mode holding flag
    thrWrite = 1'b1; cyc(1);
    chk("R5 write clears", statusReg[5], 0);
    chk("R3 idle low", statusReg[6], 0);
    thrWrite = 1'b0; txFifoEmpty = 1'b0; cyc(1);
    chk("R5 follows nonempty", statusReg[5], 0);
    txFifoEmpty = 1'b1; cyc(1);
    chk("R5 follows empty", statusReg[5], 1);
    chk("R3 idle high", statusReg[6], 1);
    ienThre = 1'b1; #1;
    chk("R6 txIrq on", txIrq, 1);
    ienThre = 1'b0; #1;
    chk("R6 txIrq off", txIrq, 0);

    // queue-mode overrun
    for (int i = 0; i < 16; i++) pushChar(8'h10 + 8'(i), 1'b0, 1'b0);
    chk("R11 no overrun when full", statusReg[1], 0);
    pushChar(8'hEE, 1'b0, 1'b0);
    chk("R11 overrun set", statusReg[1], 1);
    chk("R11 head kept", rxHeadData, 8'h10);
    pulseRead();
    chk("R11 overrun cleared", statusReg[1], 0);
    for (int i = 0; i < 15; i++) pulsePop();
    chk("R11 extra dropped", rxHeadData, 8'h1F);
    pulsePop();
    chk("R13 empty again", statusReg[0], 0);

    // line interrupt and hide-on-read
    ienLineStat = 1'b1;
    pushChar(8'h5A, 1'b1, 1'b0);
    chk("R12 lineIrq set", lineIrq, 1);
    pulseRead();
    chk("R9 parity hidden", statusReg[2], 0);
    chk("R12 lineIrq cleared", lineIrq, 0);
    chk("R2 summary kept", statusReg[7], 1);
    pulsePop();
    ienLineStat = 1'b0;

    // break, 8N1: F = 160
    serialIn = 1'b0;
    cyc(160);
    chk("R7 no break at threshold", statusReg[0], 0);
    cyc(1);
    chk("R7 break queued", statusReg[0], 1);
    chk("R7 break tag", statusReg[4], 1);
    chk("R7 break data", rxHeadData, 8'h00);
    chk("R2 break summary", statusReg[7], 1);
    pulseRead();
    chk("R9 break hidden", statusReg[4], 0);
    chk("R9 still ready", statusReg[0], 1);
    cyc(300);
    pulsePop();
    chk("R8 single break", statusReg[0], 0);
    pushChar(8'h33, 1'b0, 1'b0);
    chk("R8 char ignored low", statusReg[0], 0);
    rxStartSeen = 1'b1; cyc(1); rxStartSeen = 1'b0;
    serialIn = 1'b1; cyc(2);
    pushChar(8'h34, 1'b0, 1'b0);
    chk("R8 start before mark ignored", statusReg[0], 0);
    rxStartSeen = 1'b1; cyc(1); rxStartSeen = 1'b0;
    pushChar(8'h55, 1'b0, 1'b0);
    chk("R8 rearmed", rxHeadData, 8'h55);
    chk("R8 no break tag", statusReg[4], 0);
    pulsePop();

    // break, 5 bits + parity + 2 stop: F = 144
    wordLen = 2'd0; parityEn = 1'b1; twoStop = 1'b1;
    serialIn = 1'b0;
    cyc(144);
    chk("R7 short frame threshold", statusReg[0], 0);
    cyc(1);
    chk("R7 short frame break", statusReg[4], 1);
    serialIn = 1'b1; cyc(1);
    rxStartSeen = 1'b1; cyc(1); rxStartSeen = 1'b0;
    pulsePop();

    // single-buffer mode
    doReset(1'b0);
    chk("R1 status single", statusReg, 8'h60);
    pushChar(8'h21, 1'b1, 1'b0);
    chk("R9 single parity", statusReg[2], 1);
    chk("R2 single summary zero", statusReg[7], 0);
    pushChar(8'h77, 1'b0, 1'b0);
    chk("R11 single overrun", statusReg[1], 1);
    chk("R11 single overwrite", rxHeadData, 8'h77);
    chk("R9 new head tags", statusReg[2], 0);
    thrWrite = 1'b1; cyc(1); thrWrite = 1'b0;
    chk("R4 write clears", statusReg[5], 0);
    txShiftEmpty = 1'b0;
    thrToShift = 1'b1; cyc(1); thrToShift = 1'b0;
    chk("R4 move sets", statusReg[5], 1);
    chk("R3 shift busy", statusReg[6], 0);
    txShiftEmpty = 1'b1; #1;
    chk("R3 shift done", statusReg[6], 1);
    thrWrite = 1'b1; thrToShift = 1'b1; cyc(1);
    thrWrite = 1'b0; thrToShift = 1'b0;
    chk("R4 write wins", statusReg[5], 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule